// File: doc/BRIEF.md
# Light-Load Buck Mode Controller

This block is the digital switch-control state machine for one synchronous buck phase. It decides whether the phase runs in fixed-frequency PWM, where an external ramp modulator drives the power switches, or in a hysteretic pulse-frequency mode for light loads. In the pulse-frequency mode it drives the high-side and low-side gate enables directly.

In automatic operation the controller hands the phase over to pulse-frequency mode only after a light-load indication has been present for a qualification window of consecutive clocks, 32 by default. Inside that mode it fires high-side pulses, each followed by a low-side ramp-down, until the output is above the upper threshold. It then discharges the inductor one last time and rests in a low-power idle state. It resumes pulsing when the output sags below the lower threshold. A third, lower threshold sends the phase straight back to PWM. A configuration bit pins the phase in PWM regardless of load.

All inputs are sampled on the rising clock edge and every output is a register, so each decision shows at the ports one clock after the inputs that caused it.

Top module: `buck_mode_ctrl`

## Requirements
- R1: A synchronous active-low reset leaves the block in PWM with `pwm_mode`=1, `hs_en`=0, `ls_en`=0, `idle`=0, and the qualification count cleared.
- R2: While `force_pwm` is 1 the block never leaves PWM, and if it is set during pulse-frequency mode the block returns to PWM one clock later.
- R3: With `force_pwm`=0, `pwm_mode` falls at the clock edge where `light_load` has been sampled high on QUAL_CYCLES (default 32) consecutive edges, and not earlier.
- R4: The qualification count restarts from zero whenever `light_load` is sampled low, whenever `force_pwm` is sampled high, and whenever the block leaves pulse-frequency mode.
- R5: On entering pulse-frequency mode, and after each low-side phase, the block first spends one clock with both enables off. It then turns `hs_en` on if `out_above_hi` is 0, or enters idle if it is 1.
- R6: `hs_en` stays on until `out_above_hi` or `peak_hit` is seen. On `peak_hit` alone, the block enters a low-side phase that lasts until `zero_hit`, after which it re-evaluates the upper threshold.
- R7: If `out_above_hi` is seen during a high-side pulse (it has priority over `peak_hit`), the block runs a final low-side phase until `zero_hit` and then enters idle with both enables off.
- R8: In idle, `idle` stays 1 until `out_below_lo` is seen, after which `hs_en` turns on at the next clock.
- R9: `out_below_lo2` seen in any pulse-frequency state returns the block to PWM at the next clock, with both enables off.
- R10: `hs_en` and `ls_en` are never 1 together, and every handover between them has at least one clock with both at 0.
- R11: In PWM, `hs_en`, `ls_en` and `idle` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| force_pwm | input | 1 | Configuration bit that pins the phase in PWM |
| light_load | input | 1 | Light-load indication from the load sensor |
| out_above_hi | input | 1 | Output is above the upper hysteresis threshold |
| out_below_lo | input | 1 | Output is below the lower hysteresis threshold |
| out_below_lo2 | input | 1 | Output is below the PWM fallback threshold |
| peak_hit | input | 1 | Inductor current reached the pulse peak limit |
| zero_hit | input | 1 | Inductor current has ramped down to zero |
| hs_en | output | 1 | High-side gate enable in pulse-frequency mode |
| ls_en | output | 1 | Low-side gate enable in pulse-frequency mode |
| pwm_mode | output | 1 | 1 hands the switches to the PWM modulator |
| idle | output | 1 | Both switches off, low-power rest |

## Verification
A wrong state in the sequencer appears at the ports one clock after the edge that caused it. Depending on the state, that shows as an enable that stays on past its terminating flag, a missing dead clock between the two enables, or `idle` asserted while the output is still below the upper threshold. A miscounted qualification window shows only as `pwm_mode` falling one or more edges early or late. For that reason the bench counts edges exactly around the window, both from reset and after a return to PWM.

// File: rtl/buck_mode_pkg.sv
package buck_mode_pkg;

    typedef enum logic [2:0] {
        ST_PWM      = 3'd0,
        ST_ARM      = 3'd1,
        ST_HS       = 3'd2,
        ST_BRK_LS   = 3'd3,
        ST_LS       = 3'd4,
        ST_BRK_TAIL = 3'd5,
        ST_TAIL     = 3'd6,
        ST_IDLE     = 3'd7
    } pfm_state_e;

    typedef struct packed {
        pfm_state_e st;
        logic       hs;
        logic       ls;
        logic       idle;
        logic       pwm;
    } seq_regs_t;

endpackage

// File: rtl/light_load_qual.sv
module light_load_qual #(
    parameter int QUAL_CYCLES = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic light_load,
    input  logic force_pwm,
    input  logic in_pwm,
    output logic qual_o
);
    localparam int CW = (QUAL_CYCLES > 2) ? $clog2(QUAL_CYCLES) : 1;
    localparam logic [CW-1:0] SAT = CW'(QUAL_CYCLES - 1);

    logic [CW-1:0] cnt_d, cnt_q;
    logic          clr;

    always_comb begin
        clr    = !light_load || force_pwm || !in_pwm;
        cnt_d  = cnt_q;
        if (clr) begin
            cnt_d = '0;
        end else if (cnt_q != SAT) begin
            cnt_d = cnt_q + 1'b1;
        end
        qual_o = !clr && (cnt_q == SAT);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    AST_QUAL_NEEDS_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        qual_o |-> (light_load && !force_pwm && in_pwm)); // R3

    AST_COUNT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (!light_load || force_pwm) |=> (cnt_q == '0)); // R4

endmodule

// File: rtl/pfm_sequencer.sv
module pfm_sequencer
    import buck_mode_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic enter_i,
    input  logic force_pwm,
    input  logic above_hi,
    input  logic below_lo,
    input  logic below_lo2,
    input  logic peak_hit,
    input  logic zero_hit,
    output logic hs_o,
    output logic ls_o,
    output logic idle_o,
    output logic pwm_o
);
    seq_regs_t  r_d, r_q;
    pfm_state_e nxt;

    always_comb begin
        nxt = r_q.st;
        if (r_q.st == ST_PWM) begin
            if (enter_i) begin
                nxt = ST_ARM;
            end
        end else if (force_pwm || below_lo2) begin
            nxt = ST_PWM;
        end else begin
            case (r_q.st)
                ST_ARM:      nxt = above_hi ? ST_IDLE : ST_HS;
                ST_HS: begin
                    if (above_hi) begin
                        nxt = ST_BRK_TAIL;
                    end else if (peak_hit) begin
                        nxt = ST_BRK_LS;
                    end
                end
                ST_BRK_LS:   nxt = ST_LS;
                ST_LS:       nxt = zero_hit ? ST_ARM : ST_LS;
                ST_BRK_TAIL: nxt = ST_TAIL;
                ST_TAIL:     nxt = zero_hit ? ST_IDLE : ST_TAIL;
                ST_IDLE:     nxt = below_lo ? ST_HS : ST_IDLE;
                default:     nxt = ST_PWM;
            endcase
        end
        r_d.st   = nxt;
        r_d.hs   = (nxt == ST_HS);
        r_d.ls   = (nxt == ST_LS) || (nxt == ST_TAIL);
        r_d.idle = (nxt == ST_IDLE);
        r_d.pwm  = (nxt == ST_PWM);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.st   <= ST_PWM;
            r_q.hs   <= 1'b0;
            r_q.ls   <= 1'b0;
            r_q.idle <= 1'b0;
            r_q.pwm  <= 1'b1;
        end else begin
            r_q <= r_d;
        end
    end

    assign hs_o   = r_q.hs;
    assign ls_o   = r_q.ls;
    assign idle_o = r_q.idle;
    assign pwm_o  = r_q.pwm;

    AST_NO_SHOOT_THROUGH: assert property (@(posedge clk) disable iff (!rst_n)
        !(r_q.hs && r_q.ls)); // R10

    AST_DEAD_AFTER_HS: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(r_q.hs) |-> !r_q.ls); // R10

    AST_DEAD_AFTER_LS: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(r_q.ls) |-> !r_q.hs); // R10

    AST_FALLBACK_LO2: assert property (@(posedge clk) disable iff (!rst_n)
        (!r_q.pwm && below_lo2) |=> (r_q.pwm && !r_q.hs && !r_q.ls)); // R9

    AST_FORCE_PWM: assert property (@(posedge clk) disable iff (!rst_n)
        force_pwm |=> r_q.pwm); // R2

    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.idle && !below_lo && !below_lo2 && !force_pwm) |=> r_q.idle); // R8

    AST_PWM_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.pwm |-> (!r_q.hs && !r_q.ls && !r_q.idle)); // R11

    AST_HS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.hs && !above_hi && !peak_hit && !below_lo2 && !force_pwm) |=> r_q.hs); // R6

endmodule

// File: rtl/buck_mode_ctrl.sv
module buck_mode_ctrl #(
    parameter int QUAL_CYCLES = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic force_pwm,
    input  logic light_load,
    input  logic out_above_hi,
    input  logic out_below_lo,
    input  logic out_below_lo2,
    input  logic peak_hit,
    input  logic zero_hit,
    output logic hs_en,
    output logic ls_en,
    output logic pwm_mode,
    output logic idle
);
    logic enter_pfm;

    light_load_qual #(
        .QUAL_CYCLES(QUAL_CYCLES)
    ) u_qual (
        .clk        (clk),
        .rst_n      (rst_n),
        .light_load (light_load),
        .force_pwm  (force_pwm),
        .in_pwm     (pwm_mode),
        .qual_o     (enter_pfm)
    );

    pfm_sequencer u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .enter_i   (enter_pfm),
        .force_pwm (force_pwm),
        .above_hi  (out_above_hi),
        .below_lo  (out_below_lo),
        .below_lo2 (out_below_lo2),
        .peak_hit  (peak_hit),
        .zero_hit  (zero_hit),
        .hs_o      (hs_en),
        .ls_o      (ls_en),
        .idle_o    (idle),
        .pwm_o     (pwm_mode)
    );

    AST_ENTRY_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pwm_mode) |-> ($past(light_load) && !$past(force_pwm))); // R3

    AST_ENTRY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pwm_mode) |-> (!hs_en && !ls_en && !idle)); // R5

endmodule

// File: tb/buck_mode_ctrl_bench.sv
`timescale 1ns/1ps
module buck_mode_ctrl_bench;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic force_pwm = 1'b0, light_load = 1'b0, out_above_hi = 1'b0;
    logic out_below_lo = 1'b0, out_below_lo2 = 1'b0, peak_hit = 1'b0, zero_hit = 1'b0;
    logic hs_en, ls_en, pwm_mode, idle;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    buck_mode_ctrl u_buck_mode_ctrl (
        .clk(clk), .rst_n(rst_n), .force_pwm(force_pwm), .light_load(light_load),
        .out_above_hi(out_above_hi), .out_below_lo(out_below_lo),
        .out_below_lo2(out_below_lo2), .peak_hit(peak_hit), .zero_hit(zero_hit),
        .hs_en(hs_en), .ls_en(ls_en), .pwm_mode(pwm_mode), .idle(idle)
    );

    // inputs {force, light, above_hi, below_lo, below_lo2, peak, zero}
    // expect {pwm_mode, hs_en, ls_en, idle}
    localparam int NV = 22;
    localparam logic [10:0] VEC [NV] = '{
        {7'b0100000, 4'b0100},  // R5 ARM, below high -> HS
        {7'b0100000, 4'b0100},  // R6 HS holds
        {7'b0100010, 4'b0000},  // R6 R10 peak -> dead clock
        {7'b0100000, 4'b0010},  // R6 low-side on
        {7'b0100000, 4'b0010},  // R6 low-side holds
        {7'b0100001, 4'b0000},  // R6 zero -> ARM
        {7'b0100000, 4'b0100},  // R6 another HS pulse
        {7'b0110000, 4'b0000},  // R7 high reached -> dead clock
        {7'b0110000, 4'b0010},  // R7 final low-side
        {7'b0110001, 4'b0001},  // R7 zero -> idle
        {7'b0100000, 4'b0001},  // R8 idle ignores below-high
        {7'b0101000, 4'b0100},  // R8 below low -> HS
        {7'b0100010, 4'b0000},  // R10 peak -> dead clock
        {7'b0100000, 4'b0010},  // R6
        {7'b0110001, 4'b0000},  // R5 zero -> ARM
        {7'b0110000, 4'b0001},  // R5 ARM above high -> idle
        {7'b0101000, 4'b0100},  // R8
        {7'b0110010, 4'b0000},  // R7 high has priority over peak
        {7'b0100000, 4'b0010},  // R7 tail
        {7'b0100001, 4'b0001},  // R7 idle
        {7'b0100100, 4'b1000},  // R9 low2 -> PWM
        {7'b0100000, 4'b1000}   // R4 count restarted after exit
    };

    task automatic check(input string req, input logic [3:0] got, input logic [3:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got pwm/hs/ls/idle=%b expected %b", req, got, exp);
        end
    endtask

    task automatic drive(input logic [6:0] v);
        @(negedge clk);
        {force_pwm, light_load, out_above_hi, out_below_lo, out_below_lo2, peak_hit, zero_hit} = v;
        @(posedge clk);
        #1;
    endtask

    task automatic steps(input logic [6:0] v, input int n);
        for (int i = 0; i < n; i++) drive(v);
    endtask

    function automatic logic [3:0] outs();
        return {pwm_mode, hs_en, ls_en, idle};
    endfunction

    task automatic finish_up();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        #(5.0 * 100000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: got hung expected completion");
            finish_up();
        end
    end

    initial begin
        // R1 reset state
        steps(7'b0000000, 3);
        check("R1", outs(), 4'b1000);
        @(negedge clk) rst_n = 1'b1;

        // R3 R4: interrupted light load restarts the window
        steps(7'b0100000, 20);
        steps(7'b0000000, 1);
        check("R4", outs(), 4'b1000);
        steps(7'b0100000, 31);
        check("R3", outs(), 4'b1000);
        steps(7'b0100000, 1);
        check("R3", outs(), 4'b0000);

        // table walk through the pulse sequence
        for (int k = 0; k < NV; k++) begin
            drive(VEC[k][10:4]);
            check($sformatf("R5-R10 row %0d", k), outs(), VEC[k][3:0]);
        end

        // R4: after exit, 31 edges in total must not requalify, the 32nd does
        steps(7'b0100000, 30);
        check("R4", outs(), 4'b1000);
        steps(7'b0100000, 1);
        check("R3", outs(), 4'b0000);

        // R9 from idle
        drive(7'b0110000);
        check("R5", outs(), 4'b0001);
        drive(7'b0100100);
        check("R9", outs(), 4'b1000);

        // R2 force in pulse mode and blocking entry
        steps(7'b0100000, 32);
        check("R3", outs(), 4'b0000);
        drive(7'b1100000);
        check("R2", outs(), 4'b1000);
        steps(7'b1100000, 40);
        check("R2", outs(), 4'b1000);
        steps(7'b0100000, 31);
        check("R4", outs(), 4'b1000);

        // R1 reset from a high-side pulse
        steps(7'b0100000, 1);
        drive(7'b0100000);
        check("R5", outs(), 4'b0100);
        @(negedge clk) rst_n = 1'b0;
        @(posedge clk);
        #1;
        check("R1", outs(), 4'b1000);
        @(negedge clk) rst_n = 1'b1;
        drive(7'b0100000);
        check("R11", outs(), 4'b1000);

        done = 1'b1;
        finish_up();
    end

endmodule